// File: doc/BRIEF.md
# Memory-Bank Configuration Controller

This block loads the configuration latches of an embedded programmable fabric whose storage is organised as a grid. Every configuration latch sits where one bit line crosses one word line. The controller fetches a stored configuration image from system memory through a single-request read port. It places one row of data on the bit lines and then pulses the matching word line, so that every latch on that row captures its bit. It repeats this for each row and finally reports completion.

System memory holds up to three images, at a fixed base address plus a stride per image. A two-bit selector picks the image when programming starts. The controller can be restarted at any time while idle, so the fabric can be reloaded at run time from a different image. A reset output keeps the fabric's user logic in reset for the whole load. The selector code 3 names no image and is refused.

Top module: `mbc_config_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, sel_err, fab_rst and rd_req are 0, every word line is low and all bit lines are 0.
- R2: Row r of image s is read as WPL = ceil(NUM_BL/64) consecutive 64-bit words. Word k is read at byte address IMG_BASE + s*IMG_STRIDE + (r*WPL + k)*8, in ascending order. rd_req is a one-cycle pulse, and the next request is issued only after rd_valid has returned the previous word, whatever the memory latency.
- R3: At most one word line is high in any cycle. Rows are written in ascending order, with wl[r] the only line pulsed for row r.
- R4: Whenever wl[r] is high, bit line b carries bit b of row r. Row data is formed by placing word k of the row in bits 64k+63 down to 64k and keeping the lowest NUM_BL bits. The bit lines do not change while a word line is high.
- R5: The complete row is on the bit lines for exactly one cycle before its word line rises.
- R6: Each word line stays high for exactly WL_PULSE cycles. It is followed by one cycle with all word lines low and no read request before the next row's first fetch.
- R7: A start with a valid selector taken while idle raises busy in the next cycle. A start that arrives while busy is ignored, so the address stream and image are unchanged.
- R8: A start with selector 3 while idle raises sel_err in the next cycle and starts no reads. It also leaves done unchanged. The next accepted start clears sel_err.
- R9: done drops with an accepted start. It rises, and busy falls, in the cycle after the gap that follows the last word line. done then stays high while idle.
- R10: fab_rst is high from the cycle after an accepted start until busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Programming request |
| img_sel | input | 2 | Image selector, 0 to 2 valid |
| busy | output | 1 | Programming in progress |
| done | output | 1 | Last programming finished |
| sel_err | output | 1 | Last start carried selector 3 |
| fab_rst | output | 1 | Fabric user-logic reset |
| rd_req | output | 1 | Memory read request pulse |
| rd_addr | output | ADDR_W | Byte address of requested word |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Read data |
| bl | output | NUM_BL | Bit line drive |
| wl | output | NUM_WL | Word line strobes |

## Verification
Several properties are checked in every cycle: word lines are one-hot or idle, bit lines do not move during a strobe or at its rising edge, requests never come back to back, word lines only appear while busy, fabric reset covers busy, and done and sel_err exclude busy. The actual row contents, the address sequence per image, the exact settle and pulse lengths, and the handling of a start while busy can only be shown by the bench's scenarios. These scenarios run against a memory model with varying latency.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int MEM_WORD_W = 64;
    localparam int BYTES_PER_WORD = MEM_WORD_W / 8;
    localparam logic [1:0] SEL_RESERVED = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_SETTLE,
        ST_PULSE,
        ST_GAP
    } mbc_state_e;

    function automatic int words_for(input int nbl);
        return (nbl + MEM_WORD_W - 1) / MEM_WORD_W;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mbc_addr_gen.sv
module mbc_addr_gen
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 3,
    parameter int WORD_W = 1,
    parameter int WPL = 2,
    parameter logic [ADDR_W-1:0] IMG_BASE = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] IMG_STRIDE = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [1:0]        sel,
    input  logic [LINE_W-1:0] line,
    input  logic [WORD_W-1:0] word,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] word_index;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= IMG_BASE + ADDR_W'(sel) * IMG_STRIDE;
        end
    end

    assign word_index = ADDR_W'(line) * ADDR_W'(WPL) + ADDR_W'(word);
    assign addr = base_q + word_index * ADDR_W'(BYTES_PER_WORD);

endmodule

// File: rtl/mbc_line_buf.sv
module mbc_line_buf
    import mbc_pkg::*;
#(
    parameter int NUM_BL = 100,
    parameter int WPL = 2,
    parameter int WORD_W = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [WORD_W-1:0]     wr_idx,
    input  logic [MEM_WORD_W-1:0] wr_data,
    output logic [NUM_BL-1:0]     bl
);
    logic unused_data_bits;
    assign unused_data_bits = ^wr_data;

    for (genvar g = 0; g < WPL; g++) begin : g_slice
        localparam int LO = g * MEM_WORD_W;
        localparam int W = ((NUM_BL - LO) > MEM_WORD_W) ? MEM_WORD_W : (NUM_BL - LO);
        logic [W-1:0] slice_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slice_q <= '0;
            end else if (wr_en && (wr_idx == WORD_W'(g))) begin
                slice_q <= wr_data[W-1:0];
            end
        end

        assign bl[LO +: W] = slice_q;
    end

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int NUM_WL = 8,
    parameter int WPL = 2,
    parameter int WL_PULSE = 2,
    parameter int LINE_W = 3,
    parameter int WORD_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        sel,
    input  logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              sel_err,
    output logic              fab_rst,
    output logic              rd_req,
    output logic              load_base,
    output logic              wr_en,
    output logic [LINE_W-1:0] line,
    output logic [WORD_W-1:0] word,
    output logic [NUM_WL-1:0] wl
);
    localparam int PCNT_W = idx_width(WL_PULSE);

    mbc_state_e        state_q;
    logic [LINE_W-1:0] line_q;
    logic [WORD_W-1:0] word_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic              done_q;
    logic              err_q;
    logic              frst_q;
    logic              idle;
    logic              accept;
    logic              reject;
    logic              last_word;
    logic              last_line;
    logic              last_pulse;

    assign idle       = (state_q == ST_IDLE);
    assign accept     = idle && start && (sel != SEL_RESERVED);
    assign reject     = idle && start && (sel == SEL_RESERVED);
    assign last_word  = (word_q == WORD_W'(WPL - 1));
    assign last_line  = (line_q == LINE_W'(NUM_WL - 1));
    assign last_pulse = (pcnt_q == PCNT_W'(WL_PULSE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            word_q  <= '0;
            pcnt_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            frst_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_FETCH;
                        line_q  <= '0;
                        word_q  <= '0;
                        done_q  <= 1'b0;
                        err_q   <= 1'b0;
                        frst_q  <= 1'b1;
                    end else if (reject) begin
                        err_q <= 1'b1;
                    end
                end
                ST_FETCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (rd_valid) begin
                        if (last_word) begin
                            state_q <= ST_SETTLE;
                        end else begin
                            word_q  <= word_q + 1'b1;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_SETTLE: begin
                    pcnt_q  <= '0;
                    state_q <= ST_PULSE;
                end
                ST_PULSE: begin
                    if (last_pulse) begin
                        state_q <= ST_GAP;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (last_line) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        frst_q  <= 1'b0;
                    end else begin
                        line_q  <= line_q + 1'b1;
                        word_q  <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = !idle;
    assign done      = done_q;
    assign sel_err   = err_q;
    assign fab_rst   = frst_q;
    assign rd_req    = (state_q == ST_FETCH);
    assign load_base = accept;
    assign wr_en     = (state_q == ST_WAIT) && rd_valid;
    assign line      = line_q;
    assign word      = word_q;

    for (genvar g = 0; g < NUM_WL; g++) begin : g_wl
        assign wl[g] = (state_q == ST_PULSE) && (line_q == LINE_W'(g));
    end

endmodule

// File: rtl/mbc_config_ctrl.sv
module mbc_config_ctrl
    import mbc_pkg::*;
#(
    parameter int NUM_BL = 100,
    parameter int NUM_WL = 8,
    parameter int WL_PULSE = 2,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] IMG_BASE = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] IMG_STRIDE = 32'h0001_0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            img_sel,
    output logic                  busy,
    output logic                  done,
    output logic                  sel_err,
    output logic                  fab_rst,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_valid,
    input  logic [MEM_WORD_W-1:0] rd_data,
    output logic [NUM_BL-1:0]     bl,
    output logic [NUM_WL-1:0]     wl
);
    localparam int WPL = words_for(NUM_BL);
    localparam int WORD_W = idx_width(WPL);
    localparam int LINE_W = idx_width(NUM_WL);

    logic              load_base;
    logic              wr_en;
    logic [LINE_W-1:0] line;
    logic [WORD_W-1:0] word;

    mbc_seq #(
        .NUM_WL  (NUM_WL),
        .WPL     (WPL),
        .WL_PULSE(WL_PULSE),
        .LINE_W  (LINE_W),
        .WORD_W  (WORD_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sel      (img_sel),
        .rd_valid (rd_valid),
        .busy     (busy),
        .done     (done),
        .sel_err  (sel_err),
        .fab_rst  (fab_rst),
        .rd_req   (rd_req),
        .load_base(load_base),
        .wr_en    (wr_en),
        .line     (line),
        .word     (word),
        .wl       (wl)
    );

    mbc_addr_gen #(
        .ADDR_W    (ADDR_W),
        .LINE_W    (LINE_W),
        .WORD_W    (WORD_W),
        .WPL       (WPL),
        .IMG_BASE  (IMG_BASE),
        .IMG_STRIDE(IMG_STRIDE)
    ) u_addr (
        .clk (clk),
        .rst (rst),
        .load(load_base),
        .sel (img_sel),
        .line(line),
        .word(word),
        .addr(rd_addr)
    );

    mbc_line_buf #(
        .NUM_BL(NUM_BL),
        .WPL   (WPL),
        .WORD_W(WORD_W)
    ) u_buf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (word),
        .wr_data(rd_data),
        .bl     (bl)
    );

endmodule

// File: rtl/mbc_config_chk.sv
module mbc_config_chk #(
    parameter int NUM_BL = 100,
    parameter int NUM_WL = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              sel_err,
    input logic              fab_rst,
    input logic              rd_req,
    input logic [NUM_BL-1:0] bl,
    input logic [NUM_WL-1:0] wl
);
    // R3: never two word lines at once
    a_r3_wl_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wl));

    // R4: bit lines frozen while a strobe continues
    a_r4_bl_stable: assert property (@(posedge clk) disable iff (rst)
        ((|wl) && (|$past(wl))) |-> $stable(bl));

    // R5: row already complete in the cycle before the strobe rises
    a_r5_settle: assert property (@(posedge clk) disable iff (rst)
        $rose(|wl) |-> $stable(bl));

    // R2: requests are single-cycle pulses
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R6: strobes only during a load
    a_r6_wl_busy: assert property (@(posedge clk) disable iff (rst)
        (|wl) |-> busy);

    // R10: fabric held in reset across the whole load
    a_r10_fab_rst: assert property (@(posedge clk) disable iff (rst)
        busy |-> fab_rst);

    // R9: completion never coexists with activity
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: a refused selector never starts a load
    a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
        sel_err |-> !busy);
endmodule

bind mbc_config_ctrl mbc_config_chk #(
    .NUM_BL(NUM_BL),
    .NUM_WL(NUM_WL)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done   (done),
    .sel_err(sel_err),
    .fab_rst(fab_rst),
    .rd_req (rd_req),
    .bl     (bl),
    .wl     (wl)
);

// File: tb/tb_mbc_config_ctrl.sv
module tb_mbc_config_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_BL = 100;
    localparam int NUM_WL = 8;
    localparam int WL_PULSE = 2;
    localparam int ADDR_W = 32;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam logic [31:0] STRIDE = 32'h0001_0000;
    localparam int WPL = (NUM_BL + 63) / 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        img_sel = 2'd0;
    logic              busy, done, sel_err, fab_rst, rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_valid = 1'b0;
    logic [63:0]       rd_data = '0;
    logic [NUM_BL-1:0] bl;
    logic [NUM_WL-1:0] wl;

    int checks = 0;
    int errors = 0;
    int mem_lat = 1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbc_config_ctrl #(
        .NUM_BL(NUM_BL), .NUM_WL(NUM_WL), .WL_PULSE(WL_PULSE),
        .ADDR_W(ADDR_W), .IMG_BASE(BASE), .IMG_STRIDE(STRIDE)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .img_sel(img_sel),
        .busy(busy), .done(done), .sel_err(sel_err), .fab_rst(fab_rst),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .bl(bl), .wl(wl)
    );

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        return {a * 32'h9E37_79B1, a ^ 32'hA5A5_0F0F};
    endfunction

    function automatic logic [31:0] word_addr(input int s, input int r, input int k);
        return BASE + 32'(s) * STRIDE + 32'((r * WPL + k) * 8);
    endfunction

    function automatic logic [NUM_BL-1:0] row_data(input int s, input int r);
        logic [WPL*64-1:0] full;
        for (int k = 0; k < WPL; k++) full[k*64 +: 64] = mem_word(word_addr(s, r, k));
        return full[NUM_BL-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // memory model: answers each request after mem_lat cycles
    bit          pend = 1'b0;
    int          wait_cnt = 0;
    logic [31:0] paddr;
    always @(negedge clk) begin
        rd_valid = 1'b0;
        if (pend) begin
            if (wait_cnt == 0) begin
                rd_valid = 1'b1;
                rd_data  = mem_word(paddr);
                pend     = 1'b0;
            end else begin
                wait_cnt--;
            end
        end else if (rd_req) begin
            pend     = 1'b1;
            paddr    = rd_addr;
            wait_cnt = mem_lat - 1;
        end
    end

    task automatic program_image(input int sel, input int lat, input int inj_at,
                                 input logic [1:0] inj_sel);
        logic [31:0]       q[$];
        logic [31:0]       ea;
        logic [NUM_BL-1:0] prev_bl, prev2_bl, exp_bl;
        logic [NUM_WL-1:0] exp_wl;
        int                row = 0;
        int                pulse = 0;
        bit                fin = 1'b0;
        for (int r = 0; r < NUM_WL; r++)
            for (int k = 0; k < WPL; k++) q.push_back(word_addr(sel, r, k));
        mem_lat = lat;
        start = 1'b1;
        img_sel = 2'(sel);
        @(negedge clk);
        start = 1'b0;
        prev_bl = bl;
        prev2_bl = bl;
        chk(sel_err == 1'b0, "R8", $sformatf("sel_err=%0b exp 0 after accepted start", sel_err));
        for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
            chk(busy && fab_rst && !done, "R7",
                $sformatf("busy=%0b fab_rst=%0b done=%0b exp 1 1 0 (R10)", busy, fab_rst, done));
            chk($countones(wl) <= 1, "R3", $sformatf("wl=%b exp one-hot or zero", wl));
            if (rd_req) begin
                chk(wl == '0, "R6", $sformatf("wl=%b exp 0 during fetch", wl));
                if (q.size() == 0) begin
                    chk(1'b0, "R2", $sformatf("addr=%h exp no request", rd_addr));
                end else begin
                    ea = q.pop_front();
                    chk(rd_addr == ea, "R2", $sformatf("addr=%h exp %h", rd_addr, ea));
                end
            end
            if (|wl) begin
                exp_bl = row_data(sel, row);
                exp_wl = '0;
                exp_wl[row] = 1'b1;
                if (pulse == 0) begin
                    chk(prev_bl == exp_bl, "R5", $sformatf("settle bl=%h exp %h", prev_bl, exp_bl));
                    chk(prev2_bl != exp_bl, "R5", $sformatf("bl=%h complete two cycles early", prev2_bl));
                end
                chk(wl == exp_wl, "R3", $sformatf("wl=%b exp %b", wl, exp_wl));
                chk(bl == exp_bl, "R4", $sformatf("bl=%h exp %h", bl, exp_bl));
                pulse++;
            end else if (pulse > 0) begin
                chk(pulse == WL_PULSE, "R6", $sformatf("pulse=%0d exp %0d", pulse, WL_PULSE));
                chk(!rd_req, "R6", "rd_req=1 exp 0 in gap cycle");
                pulse = 0;
                row++;
                if (row == NUM_WL) begin
                    @(negedge clk);
                    chk(!busy && done && !fab_rst, "R9",
                        $sformatf("busy=%0b done=%0b fab_rst=%0b exp 0 1 0 (R10)", busy, done, fab_rst));
                    chk(wl == '0, "R9", $sformatf("wl=%b exp 0 when done", wl));
                    fin = 1'b1;
                end
            end
            if (cyc == inj_at) begin
                start = 1'b1;
                img_sel = inj_sel;
            end else begin
                start = 1'b0;
            end
            prev2_bl = prev_bl;
            prev_bl = bl;
            if (!fin) @(negedge clk);
        end
        start = 1'b0;
        chk(fin, "R6", $sformatf("rows written=%0d exp %0d", row, NUM_WL));
        chk(q.size() == 0, "R2", $sformatf("%0d reads missing exp 0", q.size()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !sel_err && !fab_rst && !rd_req && wl == '0 && bl == '0, "R1",
            $sformatf("in reset busy=%0b done=%0b err=%0b frst=%0b req=%0b wl=%b exp all 0",
                      busy, done, sel_err, fab_rst, rd_req, wl));
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fab_rst && wl == '0 && bl == '0, "R1",
            $sformatf("after reset busy=%0b done=%0b frst=%0b exp 0", busy, done, fab_rst));

        program_image(0, 1, -1, 2'd0);
        repeat (4) @(negedge clk);
        chk(done && !busy, "R9", $sformatf("idle done=%0b busy=%0b exp 1 0", done, busy));

        // start while busy with another selector: ignored (R7)
        program_image(1, 3, 10, 2'd2);
        program_image(2, 2, 40, 2'd0);

        // reserved selector (R8)
        start = 1'b1;
        img_sel = 2'd3;
        @(negedge clk);
        start = 1'b0;
        chk(sel_err && !busy && done, "R8",
            $sformatf("err=%0b busy=%0b done=%0b exp 1 0 1", sel_err, busy, done));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!rd_req && !busy && done, "R8",
                $sformatf("req=%0b busy=%0b done=%0b exp 0 0 1", rd_req, busy, done));
        end

        // run-time reload after the error clears it
        program_image(1, 1, -1, 2'd0);
        @(negedge clk);
        chk(done && !fab_rst, "R10", $sformatf("done=%0b frst=%0b exp 1 0", done, fab_rst));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule